// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block listens to a keyboard on the two open-drain lines of a PS/2 port, clock and data, both driven by the device. It brings both lines into the system clock domain through synchronisers. It accepts a falling edge of the device clock only after the line has stayed low for a set number of system cycles. On each accepted edge it captures one bit and builds the 11-bit frame. A frame is checked before its byte is used. Bytes that pass go to a prefix decoder, which folds the extended-key prefix (E0) and the release prefix (F0) into one key event.

Each completed event is loaded into a holding register that a processor reads through memory-mapped I/O. The register shows the 8-bit scan code, a released flag, an extended flag and a valid bit. A one-cycle read pulse clears the valid bit. If a new event arrives while an unread one is still held, the new event replaces it and an overrun flag is raised. A frame that stops part way is abandoned after an inactivity window, so the next frame starts aligned.

Top module: `ps2_key_rx`

## Requirements
- R1: While `rst` is high and in the cycle after it, `ev_valid_o`, `ev_overrun_o`, `ev_released_o`, `ev_extended_o` and `ev_code_o` are all 0.
- R2: A frame is the bit sequence start (0), eight data bits with bit 0 first, parity, stop (1). It is captured on falling edges of the device clock. A good frame carrying a byte other than E0 or F0, with no prefix pending, produces an event with that code and both flags 0.
- R3: A good F0 byte produces no event. It makes the next emitted event carry `ev_released_o` = 1.
- R4: A good E0 byte produces no event. It makes the next emitted event carry `ev_extended_o` = 1. The sequence E0 F0 code yields an event with both flags set.
- R5: Both prefix flags are cleared once an event is emitted, so a following plain code reports both flags as 0.
- R6: A frame whose data bits plus parity bit hold an even number of ones is discarded. It emits no event and does not alter pending prefix flags.
- R7: A frame whose start bit is 1 or whose stop bit is 0 is discarded and emits no event.
- R8: If a frame has begun and no accepted clock edge arrives for `TIMEOUT_CYCLES` system cycles, the bit position returns to the start of a frame. The partial frame emits no event, and the next complete frame is decoded correctly.
- R9: A low pulse on the device clock shorter than `FILT_CYCLES` system cycles is not taken as an edge and does not disturb the frame being received.
- R10: Once set, `ev_valid_o` and the event fields hold until a cycle with `rd_i` high. That read clears `ev_valid_o` and `ev_overrun_o` in the next cycle, unless a new event arrives in that same cycle.
- R11: An event arriving while `ev_valid_o` is 1 and `rd_i` is 0 sets `ev_overrun_o` and replaces the held code and flags with the new ones.
- R12: When `rd_i` is high in the same cycle that a new event arrives, the new event is loaded, `ev_valid_o` stays 1 and `ev_overrun_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Device clock line as seen at the pin (idle high) |
| ps2_data_i | input | 1 | Device data line as seen at the pin (idle high) |
| rd_i | input | 1 | One-cycle read pulse from the processor bus; clears the valid bit |
| ev_valid_o | output | 1 | An unread key event is held |
| ev_code_o | output | 8 | Scan code of the held event |
| ev_released_o | output | 1 | Held event is a key release |
| ev_extended_o | output | 1 | Held event came with the extended prefix |
| ev_overrun_o | output | 1 | An event was replaced before being read |

## Verification
The processor's read pulse and the loading of a freshly decoded event can land on the same system clock edge. The new event must then win, and no overrun may be reported. To provoke this, the bench first measures the delay from driving the last falling clock edge of a frame to the rise of `ev_valid_o`. On a later frame it places a one-cycle read pulse exactly on that loading edge. The result is judged as valid still set, new code present and overrun clear. Overrun without a read and a read without a new event are checked separately on either side of that case.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    localparam int unsigned FRAME_BITS = 11;
    localparam int unsigned DATA_BITS  = 8;

    localparam logic [DATA_BITS-1:0] PFX_EXTENDED = 8'hE0;
    localparam logic [DATA_BITS-1:0] PFX_RELEASE  = 8'hF0;

    typedef struct packed {
        logic [DATA_BITS-1:0] code;
        logic                 released;
        logic                 extended;
    } key_event_t;

    typedef enum logic [1:0] {
        BYTE_PLAIN,
        BYTE_EXT,
        BYTE_REL
    } byte_kind_e;

    // Frame acceptance: start low, stop high, odd count of ones over data and parity
    function automatic logic frame_good(input logic                 start_b,
                                        input logic [DATA_BITS-1:0] data_b,
                                        input logic                 par_b,
                                        input logic                 stop_b);
        return (start_b == 1'b0) && (stop_b == 1'b1) && ((^{data_b, par_b}) == 1'b1);
    endfunction

    function automatic byte_kind_e classify(input logic [DATA_BITS-1:0] b);
        if (b == PFX_EXTENDED) return BYTE_EXT;
        if (b == PFX_RELEASE)  return BYTE_REL;
        return BYTE_PLAIN;
    endfunction

endpackage

// File: rtl/ps2rx_line_sync.sv
module ps2rx_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[g]};
            end
        end
        assign sync_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/ps2rx_fall_filter.sv
module ps2rx_fall_filter #(
    parameter int unsigned FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic fall_o
);

    localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LOW_LAST = CW'(FILT_CYCLES - 1);

    logic [CW-1:0] low_cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            armed   <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            fall_o <= 1'b0;
            if (line_i) begin
                low_cnt <= '0;
                armed   <= 1'b1;
            end else begin
                if (low_cnt != LOW_LAST) begin
                    low_cnt <= low_cnt + 1'b1;
                end
                if (armed && (low_cnt == LOW_LAST)) begin
                    fall_o <= 1'b1;
                    armed  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/ps2rx_framer.sv
module ps2rx_framer
    import ps2rx_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYCLES = 100000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fall_i,
    input  logic                 data_i,
    output logic                 byte_stb_o,
    output logic [DATA_BITS-1:0] byte_o
);

    localparam int unsigned TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam int unsigned IW = $clog2(FRAME_BITS);
    localparam logic [TW-1:0] T_LAST    = TW'(TIMEOUT_CYCLES - 1);
    localparam logic [IW-1:0] POS_PAR   = IW'(DATA_BITS + 1);
    localparam logic [IW-1:0] POS_STOP  = IW'(FRAME_BITS - 1);

    logic [IW-1:0]        pos;
    logic [DATA_BITS-1:0] shreg;
    logic                 start_q;
    logic                 par_q;
    logic [TW-1:0]        idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos        <= '0;
            shreg      <= '0;
            start_q    <= 1'b0;
            par_q      <= 1'b0;
            idle_cnt   <= '0;
            byte_stb_o <= 1'b0;
            byte_o     <= '0;
        end else begin
            byte_stb_o <= 1'b0;
            if (fall_i) begin
                idle_cnt <= '0;
                if (pos == '0) begin
                    start_q <= data_i;
                    pos     <= pos + 1'b1;
                end else if (pos < POS_PAR) begin
                    shreg <= {data_i, shreg[DATA_BITS-1:1]};
                    pos   <= pos + 1'b1;
                end else if (pos == POS_PAR) begin
                    par_q <= data_i;
                    pos   <= POS_STOP;
                end else begin
                    pos <= '0;
                    if (frame_good(start_q, shreg, par_q, data_i)) begin
                        byte_stb_o <= 1'b1;
                        byte_o     <= shreg;
                    end
                end
            end else if (pos != '0) begin
                if (idle_cnt == T_LAST) begin
                    pos      <= '0;
                    idle_cnt <= '0;
                end else begin
                    idle_cnt <= idle_cnt + 1'b1;
                end
            end else begin
                idle_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/ps2rx_prefix_dec.sv
module ps2rx_prefix_dec
    import ps2rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_stb_i,
    input  logic [DATA_BITS-1:0] byte_i,
    output logic                 evt_stb_o,
    output key_event_t           evt_o
);

    logic       ext_pend;
    logic       rel_pend;
    byte_kind_e kind;

    always_comb begin
        kind           = classify(byte_i);
        evt_stb_o      = byte_stb_i && (kind == BYTE_PLAIN);
        evt_o.code     = byte_i;
        evt_o.released = rel_pend;
        evt_o.extended = ext_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_pend <= 1'b0;
            rel_pend <= 1'b0;
        end else if (byte_stb_i) begin
            unique case (kind)
                BYTE_EXT: ext_pend <= 1'b1;
                BYTE_REL: rel_pend <= 1'b1;
                default: begin
                    ext_pend <= 1'b0;
                    rel_pend <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ps2rx_event_reg.sv
module ps2rx_event_reg
    import ps2rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_stb_i,
    input  key_event_t evt_i,
    input  logic       rd_i,
    output logic       valid_o,
    output logic       overrun_o,
    output key_event_t held_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            overrun_o <= 1'b0;
            held_o    <= '0;
        end else if (evt_stb_i) begin
            held_o  <= evt_i;
            valid_o <= 1'b1;
            if (rd_i) begin
                overrun_o <= 1'b0;
            end else if (valid_o) begin
                overrun_o <= 1'b1;
            end
        end else if (rd_i) begin
            valid_o   <= 1'b0;
            overrun_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ps2_key_rx.sv
module ps2_key_rx
    import ps2rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned FILT_CYCLES    = 16,
    parameter int unsigned TIMEOUT_CYCLES = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_data_i,
    input  logic       rd_i,
    output logic       ev_valid_o,
    output logic [7:0] ev_code_o,
    output logic       ev_released_o,
    output logic       ev_extended_o,
    output logic       ev_overrun_o
);

    localparam int unsigned LINE_CLK  = 0;
    localparam int unsigned LINE_DATA = 1;

    logic [1:0]           raw_lines;
    logic [1:0]           sync_lines;
    logic                 fall;
    logic                 byte_stb;
    logic [DATA_BITS-1:0] byte_val;
    logic                 evt_stb;
    key_event_t           evt;
    key_event_t           held;

    assign raw_lines[LINE_CLK]  = ps2_clk_i;
    assign raw_lines[LINE_DATA] = ps2_data_i;

    ps2rx_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(raw_lines),
        .sync_o (sync_lines)
    );

    ps2rx_fall_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .line_i(sync_lines[LINE_CLK]),
        .fall_o(fall)
    );

    logic data_d;
    always_ff @(posedge clk) begin
        if (rst) data_d <= 1'b1;
        else     data_d <= sync_lines[LINE_DATA];
    end

    ps2rx_framer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .fall_i    (fall),
        .data_i    (data_d),
        .byte_stb_o(byte_stb),
        .byte_o    (byte_val)
    );

    ps2rx_prefix_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .byte_stb_i(byte_stb),
        .byte_i    (byte_val),
        .evt_stb_o (evt_stb),
        .evt_o     (evt)
    );

    ps2rx_event_reg u_evreg (
        .clk      (clk),
        .rst      (rst),
        .evt_stb_i(evt_stb),
        .evt_i    (evt),
        .rd_i     (rd_i),
        .valid_o  (ev_valid_o),
        .overrun_o(ev_overrun_o),
        .held_o   (held)
    );

    assign ev_code_o     = held.code;
    assign ev_released_o = held.released;
    assign ev_extended_o = held.extended;

endmodule

// File: rtl/ps2_key_rx_chk.sv
module ps2_key_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_i,
    input logic       evt_stb,
    input logic       ev_valid_o,
    input logic       ev_overrun_o,
    input logic [7:0] ev_code_o
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!ev_valid_o && !ev_overrun_o && ev_code_o == 8'h00));

    // R2
    event_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        evt_stb |=> ev_valid_o);

    // R10
    valid_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid_o && !rd_i) |=> ev_valid_o);

    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !evt_stb) |=> (!ev_valid_o && !ev_overrun_o));

    // R10
    code_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_stb |=> $stable(ev_code_o));

    // R11
    overrun_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_stb && ev_valid_o && !rd_i) |=> ev_overrun_o);

    // R12
    read_meets_event_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_stb && rd_i) |=> (ev_valid_o && !ev_overrun_o));

endmodule

bind ps2_key_rx ps2_key_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_i        (rd_i),
    .evt_stb     (evt_stb),
    .ev_valid_o  (ev_valid_o),
    .ev_overrun_o(ev_overrun_o),
    .ev_code_o   (ev_code_o)
);

// File: tb/ps2_key_rx_tb.sv
`timescale 1ns/1ps
module ps2_key_rx_tb;

    localparam int FILT    = 4;
    localparam int TMO     = 200;
    localparam int HALF    = 24;
    localparam int QTR     = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps2c = 1'b1;
    logic       ps2d = 1'b1;
    logic       rd = 1'b0;
    logic       ev_valid, ev_rel, ev_ext, ev_ovr;
    logic [7:0] ev_code;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ps2_key_rx #(.SYNC_STAGES(2), .FILT_CYCLES(FILT), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .ps2_clk_i    (ps2c),
        .ps2_data_i   (ps2d),
        .rd_i         (rd),
        .ev_valid_o   (ev_valid),
        .ev_code_o    (ev_code),
        .ev_released_o(ev_rel),
        .ev_extended_o(ev_ext),
        .ev_overrun_o (ev_ovr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic odd_par(input logic [7:0] b);
        return ~(^b);
    endfunction

    // mode: 0 good, 1 bad parity, 2 bad start, 3 bad stop
    // cal: 0 none, 1 measure load delay, 2 read pulse on load edge
    task automatic send_frame(input logic [7:0] b, input int mode, input int nbits,
                              input int glitch_bit, input int cal);
        logic [10:0] fr;
        bit got;
        fr = {1'b1, odd_par(b), b, 1'b0};
        if (mode == 1) fr[9]  = ~fr[9];
        if (mode == 2) fr[0]  = 1'b1;
        if (mode == 3) fr[10] = 1'b0;
        got = 0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) ps2d = fr[i];
            repeat (QTR) @(negedge clk);
            ps2c = 1'b0;
            if (i == 10 && cal == 1) begin
                for (int k = 1; k <= HALF; k++) begin
                    @(negedge clk);
                    if (!got && ev_valid) begin
                        lat = k;
                        got = 1;
                    end
                end
            end else if (i == 10 && cal == 2) begin
                repeat (lat - 1) @(negedge clk);
                rd = 1'b1;
                @(negedge clk) rd = 1'b0;
                repeat (HALF - lat) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            ps2c = 1'b1;
            if (glitch_bit == i) begin
                repeat (4) @(negedge clk);
                ps2c = 1'b0;
                repeat (FILT - 2) @(negedge clk);
                ps2c = 1'b1;
                repeat (QTR - 2 - FILT) @(negedge clk);
            end else begin
                repeat (QTR - 1) @(negedge clk);
            end
        end
        ps2d = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic good(input logic [7:0] b);
        send_frame(b, 0, 11, -1, 0);
    endtask

    task automatic read_pulse();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic expect_event(input string req, input logic [7:0] code,
                                input logic rel, input logic ext);
        chk({req, " valid"}, ev_valid, 1);
        chk({req, " code"}, ev_code, code);
        chk({req, " released"}, ev_rel, rel);
        chk({req, " extended"}, ev_ext, ext);
        read_pulse();
        chk("R10 valid cleared by read", ev_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        logic r, e;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", ev_valid, 0);
        @(negedge clk) rst = 1'b0;
        chk("R1 valid after reset", ev_valid, 0);
        chk("R1 overrun after reset", ev_ovr, 0);
        chk("R1 code after reset", ev_code, 0);
        chk("R1 flags after reset", {ev_rel, ev_ext}, 0);
        repeat (5) @(negedge clk);

        // R2 plain code, measuring the load delay
        send_frame(8'h29, 0, 11, -1, 1);
        chk("R2 load delay found", (lat > 0 && lat < HALF - 2), 1);
        expect_event("R2 plain", 8'h29, 0, 0);

        // R10 hold without read
        good(8'h1C);
        repeat (200) @(negedge clk);
        chk("R10 valid holds", ev_valid, 1);
        expect_event("R10 held code", 8'h1C, 0, 0);

        // R3 release
        good(8'hF0);
        chk("R3 prefix alone gives no event", ev_valid, 0);
        good(8'h29);
        expect_event("R3 release", 8'h29, 1, 0);

        // R4 extended, and extended release
        good(8'hE0);
        chk("R4 prefix alone gives no event", ev_valid, 0);
        good(8'h75);
        expect_event("R4 extended", 8'h75, 0, 1);
        good(8'hE0); good(8'hF0); good(8'h14);
        expect_event("R4 extended release", 8'h14, 1, 1);

        // R5 flags cleared after emission
        good(8'h14);
        expect_event("R5 flags cleared", 8'h14, 0, 0);

        // R6 bad parity discarded, prefix state kept
        send_frame(8'h1B, 1, 11, -1, 0);
        chk("R6 bad parity no event", ev_valid, 0);
        good(8'hE0);
        send_frame(8'hF0, 1, 11, -1, 0);
        good(8'h6B);
        expect_event("R6 prefix untouched", 8'h6B, 0, 1);

        // R7 bad start / stop
        send_frame(8'h2D, 2, 11, -1, 0);
        repeat (TMO + 20) @(negedge clk);
        chk("R7 bad start no event", ev_valid, 0);
        send_frame(8'h2D, 3, 11, -1, 0);
        chk("R7 bad stop no event", ev_valid, 0);
        good(8'h2D);
        expect_event("R7 recovers", 8'h2D, 0, 0);

        // R8 partial frame then timeout
        send_frame(8'h55, 0, 4, -1, 0);
        repeat (TMO + 50) @(negedge clk);
        chk("R8 partial gives no event", ev_valid, 0);
        good(8'h4A);
        expect_event("R8 realigned", 8'h4A, 0, 0);

        // R9 short glitches on the clock line
        send_frame(8'h5A, 0, 11, 3, 0);
        expect_event("R9 glitch ignored", 8'h5A, 0, 0);
        send_frame(8'h66, 0, 11, 0, 0);
        expect_event("R9 glitch after start", 8'h66, 0, 0);

        // R11 overrun
        good(8'h11);
        good(8'h12);
        chk("R11 overrun set", ev_ovr, 1);
        chk("R11 newest code", ev_code, 8'h12);
        chk("R11 valid", ev_valid, 1);
        read_pulse();
        chk("R10 overrun cleared by read", ev_ovr, 0);
        chk("R10 valid cleared after overrun", ev_valid, 0);

        // R12 read on the load edge
        good(8'h21);
        send_frame(8'h22, 0, 11, -1, 2);
        chk("R12 valid stays", ev_valid, 1);
        chk("R12 new code", ev_code, 8'h22);
        chk("R12 no overrun", ev_ovr, 0);
        read_pulse();

        // random sequences
        for (int n = 0; n < 16; n++) begin
            c = 8'($urandom_range(1, 8'hDF));
            r = 1'($urandom_range(0, 1));
            e = 1'($urandom_range(0, 1));
            if (e) good(8'hE0);
            if (r) good(8'hF0);
            good(c);
            expect_event("R2 R3 R4 random", c, r, e);
            chk("R11 random no overrun", ev_ovr, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule